// File: doc/BRIEF.md
# Serial Configuration Stream Loader with Chain Forwarding

This block sits on the configuration data input of a programmable device. While the configuration sequencer holds the load enable high, it takes a fixed number of data bits on every configuration clock: one bit in the serial build, or a wider lane such as a byte in the parallel build. It packs these bits into frame words and hands each finished word, with its frame index, to the configuration memory through a one-cycle write strobe.

A running CRC-16 covers the frame bits. After every group of frames, the stream carries a 16-bit check word. The block compares that word with the CRC it has computed and then restarts the CRC from zero. A mismatch moves the block into a fault state. In that state it raises an error flag and discards the rest of the stream until the load enable is removed.

When the final group has been accepted with a good check word, the device's own memory is full and load-done is raised. From that point the block forwards the incoming lane, one clock late, to the chain output that feeds the next device. Before that point it holds the chain output at all ones.

Top module: `cfg_serial_loader`

## Requirements
- R1: While load_en is high, the block takes LANE_W bits of din on every clock, with the earliest bit as the most significant. A frame word of WORD_W bits is built so that its first bit lands in bit WORD_W-1.
- R2: In the cycle after the clock that takes the last lane of a frame, frame_we is high for exactly one cycle. In that cycle frame_data holds the word and frame_addr holds its index. Indices count up from 0.
- R3: The CRC uses polynomial 0x8005 (x^16+x^15+x^2+1), starts at zero and processes the frame bits MSB first. After every GROUP_FRAMES frames, a 16-bit check word follows, MSB first. The CRC restarts from zero after each check word.
- R4: If a check word differs from the computed CRC, crc_err rises in the cycle after the clock that takes its last lane. After that, no frame_we occurs and the rest of the data is ignored.
- R5: crc_err stays high for as long as load_en stays high.
- R6: load_done rises in the cycle after the clock that takes the last lane of the final group's check word, provided that word matches.
- R7: dout is all ones until load_done is high. Once the block is done, dout in each cycle equals the din taken at the previous clock.
- R8: While load_en is low, nothing is accepted and frame_we stays low. crc_err and load_done clear and dout returns to all ones. A new load then starts from frame 0.
- R9: The parallel build (LANE_W = 8) reads the same stream one byte per clock, with the earliest bit in din[7]. It produces the same frames, checks and forwarding.
- R10: Exactly NUM_FRAMES frame writes occur in a complete load, and frame_addr never reaches NUM_FRAMES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load enable from the sequencer |
| din | input | LANE_W | Incoming configuration data lane |
| dout | output | LANE_W | Chain output to the next device |
| frame_we | output | 1 | One-cycle frame write strobe |
| frame_addr | output | AW | Index of the frame being written |
| frame_data | output | WORD_W | Assembled frame word |
| crc_err | output | 1 | Check word mismatch, held until load_en falls |
| load_done | output | 1 | Own memory full, forwarding active |

## Verification
The assertions assume that load_en changes only between clock edges. They also assume that, once it rises, it stays high for a whole load, because dropping it restarts the load by design. The stimulus drives din and load_en only on falling edges and streams one lane on every cycle with no gaps, since the block has no data-valid qualifier. Between loads, load_en is held low for at least one cycle.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   localparam int CHK_W = 16;
   localparam logic [CHK_W-1:0] CRC_POLY = 16'h8005;

   typedef enum logic [1:0] {
      LD_FRAME = 2'd0,
      LD_CHECK = 2'd1,
      LD_PASS  = 2'd2,
      LD_FAULT = 2'd3
   } ld_state_t;

   // one serial CRC step, data bit enters at the top
   function automatic logic [CHK_W-1:0] crc_step(input logic [CHK_W-1:0] c, input logic b);
      logic fb;
      logic [CHK_W-1:0] n;
      fb = c[CHK_W-1] ^ b;
      n  = {c[CHK_W-2:0], 1'b0};
      if (fb) n = n ^ CRC_POLY;
      return n;
   endfunction

endpackage

// File: rtl/cfg_crc_lane.sv
module cfg_crc_lane
   import cfg_loader_pkg::*;
#(
   parameter int LANE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [LANE_W-1:0] lane,
   output logic [CHK_W-1:0]  crc
);

   logic [CHK_W-1:0] crc_nxt;

   always_comb begin
      crc_nxt = crc;
      for (int i = LANE_W - 1; i >= 0; i--) begin
         crc_nxt = crc_step(crc_nxt, lane[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= crc_nxt;
   end

endmodule

// File: rtl/cfg_word_shifter.sv
module cfg_word_shifter #(
   parameter int WORD_W = 32,
   parameter int LANE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [LANE_W-1:0] lane,
   output logic [WORD_W-1:0] word_nxt
);

   logic [WORD_W-1:0] sh_q;

   generate
      if (LANE_W == WORD_W) begin : g_full_lane
         assign word_nxt = lane;
      end else begin : g_part_lane
         assign word_nxt = {sh_q[WORD_W-LANE_W-1:0], lane};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sh_q <= '0;
      else if (clr) sh_q <= '0;
      else if (en)  sh_q <= word_nxt;
   end

endmodule

// File: rtl/cfg_chain_out.sv
module cfg_chain_out #(
   parameter int LANE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pass,
   input  logic [LANE_W-1:0] din,
   output logic [LANE_W-1:0] dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dout <= '1;
      else if (!pass) dout <= '1;
      else            dout <= din;
   end

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_loader_pkg::*;
#(
   parameter int  LANE_W       = 1,
   parameter int  WORD_W       = 32,
   parameter int  NUM_FRAMES   = 64,
   parameter int  GROUP_FRAMES = 8,
   localparam int AW           = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [LANE_W-1:0] din,
   output logic [LANE_W-1:0] dout,
   output logic              frame_we,
   output logic [AW-1:0]     frame_addr,
   output logic [WORD_W-1:0] frame_data,
   output logic              crc_err,
   output logic              load_done
);

   localparam int LPW  = WORD_W / LANE_W;
   localparam int CLN  = CHK_W / LANE_W;
   localparam int LC_W = (LPW > 1) ? $clog2(LPW) : 1;
   localparam int GW   = (GROUP_FRAMES > 1) ? $clog2(GROUP_FRAMES) : 1;
   localparam int FT_W = $clog2(NUM_FRAMES + 1);

   generate
      if (CHK_W % LANE_W != 0) begin : g_bad_lane
         $error("LANE_W must divide the 16-bit check word");
      end
      if (WORD_W % LANE_W != 0 || WORD_W < CHK_W) begin : g_bad_word
         $error("WORD_W must be a multiple of LANE_W and at least 16");
      end
      if (NUM_FRAMES < 2 || NUM_FRAMES % GROUP_FRAMES != 0) begin : g_bad_frames
         $error("NUM_FRAMES must be >= 2 and a multiple of GROUP_FRAMES");
      end
   endgenerate

   ld_state_t         state;
   logic [LC_W-1:0]   lane_cnt;
   logic [GW-1:0]     grp_cnt;
   logic [FT_W-1:0]   frame_total;
   logic [WORD_W-1:0] word_nxt;
   logic [CHK_W-1:0]  crc;
   logic              accept, in_frame, word_end, chk_end, crc_match;

   assign in_frame  = (state == LD_FRAME);
   assign accept    = load_en && (in_frame || state == LD_CHECK);
   assign word_end  = accept && in_frame && (lane_cnt == LC_W'(LPW - 1));
   assign chk_end   = accept && (state == LD_CHECK) && (lane_cnt == LC_W'(CLN - 1));
   assign crc_match = (word_nxt[CHK_W-1:0] == crc);

   cfg_word_shifter #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(!load_en), .en(accept),
      .lane(din), .word_nxt(word_nxt)
   );

   cfg_crc_lane #(.LANE_W(LANE_W)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(!load_en || chk_end),
      .en(accept && in_frame), .lane(din), .crc(crc)
   );

   cfg_chain_out #(.LANE_W(LANE_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .pass(load_en && state == LD_PASS),
      .din(din), .dout(dout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= LD_FRAME;
         lane_cnt    <= '0;
         grp_cnt     <= '0;
         frame_total <= '0;
         frame_we    <= 1'b0;
         frame_addr  <= '0;
         frame_data  <= '0;
         crc_err     <= 1'b0;
         load_done   <= 1'b0;
      end else if (!load_en) begin
         state       <= LD_FRAME;
         lane_cnt    <= '0;
         grp_cnt     <= '0;
         frame_total <= '0;
         frame_we    <= 1'b0;
         crc_err     <= 1'b0;
         load_done   <= 1'b0;
      end else begin
         frame_we <= 1'b0;
         if (accept) begin
            if (word_end || chk_end) lane_cnt <= '0;
            else                     lane_cnt <= lane_cnt + 1'b1;
         end
         if (word_end) begin
            frame_we    <= 1'b1;
            frame_data  <= word_nxt;
            frame_addr  <= frame_total[AW-1:0];
            frame_total <= frame_total + 1'b1;
            if (grp_cnt == GW'(GROUP_FRAMES - 1)) begin
               grp_cnt <= '0;
               state   <= LD_CHECK;
            end else begin
               grp_cnt <= grp_cnt + 1'b1;
            end
         end
         if (chk_end) begin
            if (!crc_match) begin
               state   <= LD_FAULT;
               crc_err <= 1'b1;
            end else if (frame_total == FT_W'(NUM_FRAMES)) begin
               state     <= LD_PASS;
               load_done <= 1'b1;
            end else begin
               state <= LD_FRAME;
            end
         end
      end
   end

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
   parameter int LANE_W     = 1,
   parameter int NUM_FRAMES = 64,
   parameter int AW         = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_en,
   input logic [LANE_W-1:0] din,
   input logic [LANE_W-1:0] dout,
   input logic              frame_we,
   input logic [AW-1:0]     frame_addr,
   input logic              crc_err,
   input logic              load_done
);

   localparam logic [LANE_W-1:0] ALL_ONES = '1;

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_en) |-> (!frame_we && !crc_err && !load_done && dout == ALL_ONES));

   // R5
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(crc_err) && $past(load_en)) |-> crc_err);

   // R4
   err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(crc_err) |-> !frame_we);

   // R6
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(crc_err && load_done));

   // R7
   hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_done) |-> dout == ALL_ONES);

   // R7
   forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load_done) && $past(load_en)) |-> dout == $past(din));

   // R2
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we |=> !frame_we);

   // R10
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we |-> (int'(frame_addr) < NUM_FRAMES));

endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
   .LANE_W(LANE_W), .NUM_FRAMES(NUM_FRAMES), .AW(AW)
) u_chk (.*);

// File: tb/cfg_serial_loader_bench.sv
`timescale 1ns/1ps
module cfg_serial_loader_bench;

   localparam int NF = 4;
   localparam int GF = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_s = 1'b0, ld_p = 1'b0;
   logic din_s = 1'b0;
   logic [7:0] din_p = 8'h00;

   logic dout_s, we_s, err_s, done_s;
   logic [1:0] addr_s;
   logic [31:0] data_s;
   logic [7:0] dout_p;
   logic we_p, err_p, done_p;
   logic [1:0] addr_p;
   logic [31:0] data_p;

   always #2 clk = ~clk;

   cfg_serial_loader #(.LANE_W(1), .NUM_FRAMES(NF), .GROUP_FRAMES(GF)) u_cfg_serial_loader (
      .clk(clk), .rst_n(rst_n), .load_en(ld_s), .din(din_s), .dout(dout_s),
      .frame_we(we_s), .frame_addr(addr_s), .frame_data(data_s),
      .crc_err(err_s), .load_done(done_s));

   cfg_serial_loader #(.LANE_W(8), .NUM_FRAMES(NF), .GROUP_FRAMES(GF)) u_cfg_serial_loader_par (
      .clk(clk), .rst_n(rst_n), .load_en(ld_p), .din(din_p), .dout(dout_p),
      .frame_we(we_p), .frame_addr(addr_p), .frame_data(data_p),
      .crc_err(err_p), .load_done(done_p));

   int n_chk = 0, n_bad = 0;
   int slen;
   logic sbits [0:255];
   logic [7:0] sbytes [0:63];
   logic m_we [0:255];
   logic [1:0] m_addr [0:255];
   logic [31:0] m_data [0:255];
   logic m_err [0:255];
   logic m_done [0:255];
   logic [7:0] m_dout [0:255];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [31:0] w);
      logic [15:0] r;
      logic fb;
      r = c;
      for (int i = 31; i >= 0; i--) begin
         fb = r[15] ^ w[i];
         r = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h8005;
      end
      return r;
   endfunction

   function automatic logic [31:0] frame_val(input logic [31:0] seed, input int k);
      return seed ^ (32'h9E3779B9 * (k + 1)) ^ {k[7:0], 24'h0};
   endfunction

   task automatic build(input logic [31:0] seed, input int bad_grp);
      int p;
      p = 0;
      for (int g = 0; g < NF / GF; g++) begin
         logic [15:0] c;
         logic [15:0] cw;
         c = '0;
         for (int f = 0; f < GF; f++) begin
            logic [31:0] w;
            w = frame_val(seed, g * GF + f);
            c = crc_word(c, w);
            for (int i = 31; i >= 0; i--) begin sbits[p] = w[i]; p++; end
         end
         cw = (g == bad_grp) ? (c ^ 16'h0100) : c;
         for (int i = 15; i >= 0; i--) begin sbits[p] = cw[i]; p++; end
      end
      for (int e = 0; e < 40; e++) begin
         sbits[p] = (((e * 5) + int'(seed[0])) % 3) == 1;
         p++;
      end
      slen = p;
      for (int b = 0; b < slen / 8; b++) begin
         for (int i = 0; i < 8; i++) sbytes[b][7-i] = sbits[b*8+i];
      end
   endtask

   task automatic record(input bit par, input int n);
      m_we[n]   = par ? we_p : we_s;
      m_addr[n] = par ? addr_p : addr_s;
      m_data[n] = par ? data_p : data_s;
      m_err[n]  = par ? err_p : err_s;
      m_done[n] = par ? done_p : done_s;
      m_dout[n] = par ? dout_p : {7'b0, dout_s};
   endtask

   task automatic run(input bit par, input bit en, input int len);
      for (int n = 0; n <= len; n++) begin
         @(negedge clk);
         record(par, n);
         if (par) begin
            ld_p = en;
            din_p = (n < len) ? sbytes[n] : 8'h00;
         end else begin
            ld_s = en;
            din_s = (n < len) ? sbits[n] : 1'b0;
         end
      end
   endtask

   task automatic drop_enable(input bit par);
      @(negedge clk);
      if (par) ld_p = 1'b0; else ld_s = 1'b0;
      @(negedge clk);
      record(par, 0);
      chk(!m_err[0] && !m_done[0] && !m_we[0], "R8 clear after enable low",
          {29'b0, m_err[0], m_done[0], m_we[0]}, 32'h0);
      chk(m_dout[0] == (par ? 8'hFF : 8'h01), "R8 dout high after enable low", m_dout[0], par ? 8'hFF : 8'h01);
   endtask

   function automatic logic [7:0] lane_at(input bit par, input int n);
      return par ? sbytes[n] : {7'b0, sbits[n]};
   endfunction

   task automatic check_good(input bit par, input logic [31:0] seed, input int len);
      int lpf, cl, gl, last, lc, wes;
      logic [7:0] ones, exp;
      lpf = par ? 4 : 32;
      cl = par ? 2 : 16;
      gl = GF * lpf + cl;
      ones = par ? 8'hFF : 8'h01;
      for (int k = 0; k < NF; k++) begin
         last = (k / GF) * gl + (k % GF) * lpf + lpf - 1;
         chk(m_we[last+1] == 1'b1, par ? "R9 R2 strobe" : "R2 strobe", m_we[last+1], 1);
         chk(m_addr[last+1] == 2'(k), "R2 index", m_addr[last+1], k);
         chk(m_data[last+1] == frame_val(seed, k), par ? "R9 R1 word" : "R1 word",
             m_data[last+1], frame_val(seed, k));
      end
      wes = 0;
      for (int n = 0; n <= len; n++) if (m_we[n]) wes++;
      chk(wes == NF, "R10 write count", wes, NF);
      lc = 2 * gl - 1;
      chk(m_done[lc] == 1'b0 && m_done[lc+1] == 1'b1, "R6 done timing",
          {m_done[lc], m_done[lc+1]}, 32'h1);
      chk(m_done[len] == 1'b1 && m_err[len] == 1'b0, "R3 R6 good CRC, done held",
          {m_done[len], m_err[len]}, 32'h2);
      for (int n = 1; n <= len; n++) begin
         exp = (n - 1 >= lc + 1) ? lane_at(par, n - 1) : ones;
         chk(m_dout[n] == exp, par ? "R9 R7 chain out" : "R7 chain out", m_dout[n], exp);
      end
   endtask

   task automatic check_bad(input bit par, input int bad_grp, input int len);
      int lpf, cl, gl, lc, wes;
      lpf = par ? 4 : 32;
      cl = par ? 2 : 16;
      gl = GF * lpf + cl;
      lc = bad_grp * gl + gl - 1;
      chk(m_err[lc] == 1'b0 && m_err[lc+1] == 1'b1, "R4 error timing",
          {m_err[lc], m_err[lc+1]}, 32'h1);
      chk(m_err[len] == 1'b1, "R5 error held", m_err[len], 1);
      wes = 0;
      for (int n = 0; n <= len; n++) if (m_we[n]) wes++;
      chk(wes == (bad_grp + 1) * GF, "R4 writes stop after mismatch", wes, (bad_grp + 1) * GF);
      chk(m_done[len] == 1'b0, "R4 no done after mismatch", m_done[len], 0);
      chk(m_dout[len] == (par ? 8'hFF : 8'h01), "R4 stream not forwarded", m_dout[len], par ? 8'hFF : 8'h01);
   endtask

   bit finished = 1'b0;

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(dout_s == 1'b1 && !we_s && !err_s && !done_s, "R7 reset state",
          {dout_s, we_s, err_s, done_s}, 32'h8);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dout_p == 8'hFF && !we_p && !done_p, "R7 R9 reset state", dout_p, 8'hFF);

      // R8: stream while disabled is ignored
      build(32'h0, -1);
      run(1'b0, 1'b0, slen);
      begin
         int wes;
         wes = 0;
         for (int n = 0; n <= slen; n++) if (m_we[n]) wes++;
         chk(wes == 0, "R8 no writes when disabled", wes, 0);
         chk(m_dout[slen] == 8'h01 && !m_done[slen], "R8 no load when disabled", m_dout[slen], 1);
      end

      // R1 R2 R3 R6 R7 R10: good loads with several patterns
      foreach (sbytes[i]) sbytes[i] = 8'h00;
      build(32'h0, -1);
      run(1'b0, 1'b1, slen);
      check_good(1'b0, 32'h0, slen);
      drop_enable(1'b0);

      build(32'hFFFF_FFFF, -1);
      run(1'b0, 1'b1, slen);
      check_good(1'b0, 32'hFFFF_FFFF, slen);
      drop_enable(1'b0);

      // R4 R5: mismatch in first and in second group
      for (int bg = 0; bg < NF / GF; bg++) begin
         build(32'h1357_9BDF, bg);
         run(1'b0, 1'b1, slen);
         check_bad(1'b0, bg, slen);
         drop_enable(1'b0);
      end

      // R9: parallel build, good then bad
      build(32'hC0DE_5A5A, -1);
      run(1'b1, 1'b1, slen / 8);
      check_good(1'b1, 32'hC0DE_5A5A, slen / 8);
      drop_enable(1'b1);

      build(32'h0F0F_1234, 1);
      run(1'b1, 1'b1, slen / 8);
      check_bad(1'b1, 1, slen / 8);
      drop_enable(1'b1);

      // R8: reload after clear starts at frame 0
      build(32'hA5A5_0001, -1);
      run(1'b0, 1'b1, slen);
      check_good(1'b0, 32'hA5A5_0001, slen);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule